// File: doc/BRIEF.md
# Stack Push/Pop Sequencer

A multi-cycle controller that moves 16-bit register pairs between a register file and a byte-wide, single-port memory. It owns the 16-bit stack pointer and carries out six operations:

- pushing a pair;
- popping a pair;
- exchanging the HL pair with the two bytes on top of the stack;
- loading the stack pointer from HL;
- pushing a return address (call);
- popping a program counter value (return).

The register file sits outside the block. On `start`, the value to store (pair, HL or return address) arrives on `din`. Results leave on `dout` with a write strobe for the pair file or for the program counter.

The memory is expected to have a registered read: data for the address presented in one cycle appears on `mem_rdata` in the next cycle. Exactly one memory access is made per clock. A push lowers the stack pointer before each byte it stores, high byte first. A pop reads the low byte first and raises the pointer after each byte. The stack pointer wraps modulo 2^16 in both directions. `done` is a single-cycle strobe in the cycle that carries the last write or register update.

Top module: `stack_seq`

## Requirements
- R1: Push (`op`=0) accepted at stack pointer S writes din[15:8] to address S-1, then din[7:0] to address S-2, and leaves the pointer at S-2; `done` is high in the second cycle after the accepting edge.
- R2: Pop (`op`=1) at pointer S forms `dout` = {mem[S+1], mem[S]}. It raises `dout_we` with `dout_sel` equal to the `pair_sel` captured at start (0 BC, 1 DE, 2 HL, 3 AF) and leaves the pointer at S+2; `done` is high in the third cycle after the accepting edge.
- R3: Exchange (`op`=2) at pointer S returns {mem[S+1], mem[S]} on `dout` with `dout_we` and `dout_sel`=2 (HL). It stores din[7:0] at S and din[15:8] at S+1, leaves the pointer at S, and signals `done` in the fourth cycle after the accepting edge.
- R4: Pointer load (`op`=3) sets the stack pointer to `din`, and `done` is high in the first cycle after the accepting edge.
- R5: Call (`op`=4) stores `din` exactly as a push does. Return (`op`=5) reads as a pop does but raises `pc_we` instead of `dout_we`; the two strobes are never high together.
- R6: Stack pointer arithmetic and the S+1 address wrap modulo 2^16 (0000 minus 1 is FFFF, FFFF plus 1 is 0000).
- R7: `mem_we` is high only while an operation is in progress, never in the idle state.
- R8: `done` lasts exactly one cycle, and a `start` seen while an operation is in progress is ignored.
- R9: Reserved opcodes 6 and 7 are ignored: no `done`, no memory write, and the stack pointer is unchanged.
- R10: After a synchronous active-low reset the stack pointer equals the SP_INIT parameter (default 0000), and `done` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the operation on `op` (taken only when idle) |
| op | input | 3 | Operation code: 0 push, 1 pop, 2 exchange, 3 pointer load, 4 call, 5 return |
| pair_sel | input | 2 | Register pair for pop write-back: 0 BC, 1 DE, 2 HL, 3 AF |
| din | input | 16 | Pair, HL or return address value to store |
| dout | output | 16 | Popped or exchanged value, or new program counter |
| dout_we | output | 1 | Write `dout` into pair `dout_sel` |
| dout_sel | output | 2 | Destination pair for `dout_we` |
| pc_we | output | 1 | Load `dout` into the program counter |
| done | output | 1 | One-cycle completion strobe |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after its address |

## Verification
The bench drives pushes and pops across the 0000/FFFF boundary. A design that skipped wrap handling would leave the pointer at a wrong value or place bytes at the wrong addresses. It runs an exchange with the pointer at FFFF: a design that moved the pointer or failed to wrap S+1 would return the wrong pair and leave the pointer displaced. It also swaps byte order on push versus pop and checks the bytes one by one, which catches a swapped half. Finally, it issues reserved opcodes and a start that arrives while an operation is in progress; a design that acted on either would pulse `done` or corrupt the pointer.

// File: rtl/stack_seq_pkg.sv
// Package: shared encodings for the stack sequencer.
// Assumes a byte-wide memory and pairs made of two bytes.
package stack_seq_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_XCHG = 3'd2,
        OP_LDSP = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_WHI, S_WLO, S_RLO, S_RHI, S_REND,
        S_XR0, S_XR1, S_XW0, S_XW1, S_LDONE
    } state_e;

    typedef enum logic [1:0] {
        SP_HOLD, SP_DEC, SP_INC, SP_LOAD
    } sp_cmd_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] PAIR_HL = 2'd2;

endpackage

// File: rtl/stack_seq_sp.sv
// Stack pointer register: holds, steps by one in either direction with
// modulo wrap, or loads a new value. Also offers pointer+1 for addressing.
// Assumes one command per clock from the sequencer.
module stack_seq_sp
    import stack_seq_pkg::*;
#(
    parameter int          AW      = 16,
    parameter logic [AW-1:0] SP_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sp_cmd_e       cmd,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_plus1
);
    localparam logic [AW-1:0] ONE = 1;

    logic [AW-1:0] sp_q;

    // Pointer update per command; wraps naturally at AW bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_INIT;
        end else begin
            unique case (cmd)
                SP_DEC:  sp_q <= sp_q - ONE;
                SP_INC:  sp_q <= sp_q + ONE;
                SP_LOAD: sp_q <= load_val;
                default: sp_q <= sp_q;
            endcase
        end
    end

    assign sp       = sp_q;
    assign sp_plus1 = sp_q + ONE;
endmodule

// File: rtl/stack_seq_fsm.sv
// Sequencer: walks the memory cycles of each operation, steers the memory
// port, captures read bytes and raises the write-back strobes.
// Assumes memory read data arrives one cycle after its address.
module stack_seq_fsm
    import stack_seq_pkg::*;
#(
    parameter int BW = 8,
    localparam int PW = 2 * BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [SEL_W-1:0] pair_sel,
    input  logic [PW-1:0]    din,
    input  logic [BW-1:0]    mem_rdata,
    input  logic [PW-1:0]    sp,
    input  logic [PW-1:0]    sp_plus1,
    output sp_cmd_e          sp_cmd,
    output logic [PW-1:0]    mem_addr,
    output logic [BW-1:0]    mem_wdata,
    output logic             mem_we,
    output logic [PW-1:0]    dout,
    output logic             dout_we,
    output logic [SEL_W-1:0] dout_sel,
    output logic             pc_we,
    output logic             done,
    output logic             busy
);
    state_e           state;
    logic [PW-1:0]    data_q;
    logic [SEL_W-1:0] sel_q;
    logic             ret_q;
    logic [BW-1:0]    lo_q;
    logic [BW-1:0]    hi_q;

    // State walk, operand capture and read-byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            data_q <= '0;
            sel_q  <= '0;
            ret_q  <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        data_q <= din;
                        sel_q  <= pair_sel;
                        ret_q  <= (op == OP_RET);
                        case (op)
                            OP_PUSH, OP_CALL: state <= S_WHI;
                            OP_POP,  OP_RET:  state <= S_RLO;
                            OP_XCHG:          state <= S_XR0;
                            OP_LDSP:          state <= S_LDONE;
                            default:          state <= S_IDLE;
                        endcase
                    end
                end
                S_WHI:   state <= S_WLO;
                S_RLO:   state <= S_RHI;
                S_RHI: begin
                    lo_q  <= mem_rdata;
                    state <= S_REND;
                end
                S_XR0:   state <= S_XR1;
                S_XR1: begin
                    lo_q  <= mem_rdata;
                    state <= S_XW0;
                end
                S_XW0: begin
                    hi_q  <= mem_rdata;
                    state <= S_XW1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Per-state memory port, pointer command and completion outputs.
    always_comb begin
        sp_cmd    = SP_HOLD;
        mem_addr  = sp;
        mem_wdata = '0;
        mem_we    = 1'b0;
        dout      = {hi_q, lo_q};
        dout_we   = 1'b0;
        dout_sel  = sel_q;
        pc_we     = 1'b0;
        done      = 1'b0;
        busy      = (state != S_IDLE);
        unique case (state)
            S_IDLE: begin
                if (start && (op == OP_PUSH || op == OP_CALL)) sp_cmd = SP_DEC;
                if (start && op == OP_LDSP)                    sp_cmd = SP_LOAD;
            end
            S_WHI: begin
                mem_we    = 1'b1;
                mem_wdata = data_q[PW-1:BW];
                sp_cmd    = SP_DEC;
            end
            S_WLO: begin
                mem_we    = 1'b1;
                mem_wdata = data_q[BW-1:0];
                done      = 1'b1;
            end
            S_RLO, S_RHI: sp_cmd = SP_INC;
            S_REND: begin
                dout    = {mem_rdata, lo_q};
                done    = 1'b1;
                pc_we   = ret_q;
                dout_we = !ret_q;
            end
            S_XR1: mem_addr = sp_plus1;
            S_XW0: begin
                mem_we    = 1'b1;
                mem_wdata = data_q[BW-1:0];
            end
            S_XW1: begin
                mem_addr  = sp_plus1;
                mem_we    = 1'b1;
                mem_wdata = data_q[PW-1:BW];
                done      = 1'b1;
                dout_we   = 1'b1;
                dout_sel  = PAIR_HL;
            end
            S_LDONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/stack_seq.sv
// Top: stack push/pop sequencer. Combines the pointer register with the
// operation sequencer. Assumes a single-port memory with registered read.
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PAIR_W = 2 * BYTE_W,
    parameter logic [PAIR_W-1:0] SP_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [SEL_W-1:0]  pair_sel,
    input  logic [PAIR_W-1:0] din,
    output logic [PAIR_W-1:0] dout,
    output logic              dout_we,
    output logic [SEL_W-1:0]  dout_sel,
    output logic              pc_we,
    output logic              done,
    output logic [PAIR_W-1:0] sp,
    output logic [PAIR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [BYTE_W-1:0] mem_rdata
);
    sp_cmd_e           sp_cmd;
    logic [PAIR_W-1:0] sp_plus1;
    logic              busy;

    stack_seq_sp #(.AW(PAIR_W), .SP_INIT(SP_INIT)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (sp_cmd),
        .load_val (din),
        .sp       (sp),
        .sp_plus1 (sp_plus1)
    );

    stack_seq_fsm #(.BW(BYTE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .pair_sel  (pair_sel),
        .din       (din),
        .mem_rdata (mem_rdata),
        .sp        (sp),
        .sp_plus1  (sp_plus1),
        .sp_cmd    (sp_cmd),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .dout      (dout),
        .dout_we   (dout_we),
        .dout_sel  (dout_sel),
        .pc_we     (pc_we),
        .done      (done),
        .busy      (busy)
    );
endmodule

// File: rtl/stack_seq_chk.sv
// Checker: temporal properties of the stack sequencer, bound to the top.
// Assumes reset is held low from time zero for at least one clock.
module stack_seq_chk #(
    parameter int PW = 16,
    parameter logic [PW-1:0] SP_INIT = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    op,
    input logic [PW-1:0] din,
    input logic [PW-1:0] sp,
    input logic          done,
    input logic          mem_we,
    input logic          dout_we,
    input logic          pc_we,
    input logic          busy
);
    localparam logic [PW-1:0] TWO = 2;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (sp == SP_INIT && !done && !mem_we)); // R10

    AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (op == 3'd0 || op == 3'd4)) |-> ##2 (done && sp == $past(sp, 2) - TWO)); // R1

    AST_POP_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (op == 3'd1 || op == 3'd5)) |-> ##3 (done && sp == $past(sp, 3) + TWO)); // R2

    AST_XCHG_SP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 3'd2) |-> ##4 (done && sp == $past(sp, 4))); // R3

    AST_LOAD_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 3'd3) |=> (done && sp == $past(din))); // R4

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout_we && pc_we)); // R5

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op >= 3'd6) |=> (!busy && $stable(sp))); // R9
endmodule

bind stack_seq stack_seq_chk #(.PW(PAIR_W), .SP_INIT(SP_INIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .din     (din),
    .sp      (sp),
    .done    (done),
    .mem_we  (mem_we),
    .dout_we (dout_we),
    .pc_we   (pc_we),
    .busy    (busy)
);

// File: tb/stack_seq_tb.sv
// Bench: a vector table walked by one loop, then directed wrap, reserved
// opcode, busy-start and reset tests. Memory is a 256-byte model here.
module stack_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  sel_i = '0;
    logic [15:0] din_i = '0;
    logic [15:0] dout, sp, mem_addr;
    logic        dout_we, pc_we, done, mem_we;
    logic [1:0]  dout_sel;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  ram [256];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int we_cnt = 0;
    int done_cnt = 0;

    always #4 clk = ~clk;

    stack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .pair_sel(sel_i),
        .din(din_i), .dout(dout), .dout_we(dout_we), .dout_sel(dout_sel),
        .pc_we(pc_we), .done(done), .sp(sp), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // Registered-read memory model, plus write and done counters.
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[7:0]];
        if (mem_we) we_cnt <= we_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            errors = errors + 1;
            $display("FAIL R8 watchdog expired act=%0d exp<%0d", cyc, 50000);
            summary();
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sel;
        logic [15:0] din;
        logic [15:0] exp_out;
        logic [15:0] exp_sp;
        logic [3:0]  exp_lat;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'd3, 2'd0, 16'h0080, 16'h0000, 16'h0080, 4'd1},
        '{3'd0, 2'd0, 16'h1234, 16'h0000, 16'h007E, 4'd2},
        '{3'd0, 2'd3, 16'hABCD, 16'h0000, 16'h007C, 4'd2},
        '{3'd1, 2'd1, 16'h0000, 16'hABCD, 16'h007E, 4'd3},
        '{3'd4, 2'd0, 16'h5678, 16'h0000, 16'h007C, 4'd2},
        '{3'd5, 2'd0, 16'h0000, 16'h5678, 16'h007E, 4'd3},
        '{3'd2, 2'd0, 16'hBEEF, 16'h1234, 16'h007E, 4'd4},
        '{3'd1, 2'd2, 16'h0000, 16'hBEEF, 16'h0080, 4'd3}
    };

    logic [15:0] g_out;
    logic        g_we, g_pc;
    logic [1:0]  g_sel;
    int          g_lat;

    // Issue one operation, wait for done, then one settle cycle.
    task automatic run_op(input logic [2:0] op, input logic [1:0] sel, input logic [15:0] din);
        @(negedge clk);
        start = 1'b1; op_i = op; sel_i = sel; din_i = din;
        g_lat = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (done && g_lat == 0) begin
                g_lat = k; g_out = dout; g_we = dout_we; g_pc = pc_we; g_sel = dout_sel;
            end
            if (g_lat != 0) break;
        end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R10 sp after reset", sp, 16'h0000);
        chk("R10 done low in reset", {15'd0, done}, 16'd0);
        chk("R10 mem_we low in reset", {15'd0, mem_we}, 16'd0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            run_op(VEC[i].op, VEC[i].sel, VEC[i].din);
            chk("R8 latency to done", 16'(g_lat), {12'd0, VEC[i].exp_lat});
            chk("R1 R2 R3 R4 sp after op", sp, VEC[i].exp_sp);
            case (VEC[i].op)
                3'd0, 3'd4: begin
                    chk("R1 R5 high byte at S-1", {8'd0, ram[8'(VEC[i].exp_sp + 16'd1)]}, {8'd0, VEC[i].din[15:8]});
                    chk("R1 R5 low byte at S-2", {8'd0, ram[VEC[i].exp_sp[7:0]]}, {8'd0, VEC[i].din[7:0]});
                    chk("R1 no write-back", {14'd0, g_we, g_pc}, 16'd0);
                end
                3'd1: begin
                    chk("R2 popped pair", g_out, VEC[i].exp_out);
                    chk("R2 strobes we,pc", {14'd0, g_we, g_pc}, 16'd2);
                    chk("R2 dest pair", {14'd0, g_sel}, {14'd0, VEC[i].sel});
                end
                3'd5: begin
                    chk("R5 return value", g_out, VEC[i].exp_out);
                    chk("R5 strobes we,pc", {14'd0, g_we, g_pc}, 16'd1);
                end
                3'd2: begin
                    chk("R3 old top of stack", g_out, VEC[i].exp_out);
                    chk("R3 strobe and HL sel", {13'd0, g_we, g_sel}, 16'd6);
                    chk("R3 L stored at S", {8'd0, ram[VEC[i].exp_sp[7:0]]}, {8'd0, VEC[i].din[7:0]});
                    chk("R3 H stored at S+1", {8'd0, ram[8'(VEC[i].exp_sp + 16'd1)]}, {8'd0, VEC[i].din[15:8]});
                end
                default: chk("R4 no write-back", {14'd0, g_we, g_pc}, 16'd0);
            endcase
        end

        // Reset again, then wrap below zero on push.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 sp after second reset", sp, 16'h0000);
        rst_n = 1'b1;
        run_op(3'd0, 2'd0, 16'hA5C3);
        chk("R6 push wraps sp", sp, 16'hFFFE);
        chk("R6 high byte at FFFF", {8'd0, ram[8'hFF]}, 16'h00A5);
        chk("R6 low byte at FFFE", {8'd0, ram[8'hFE]}, 16'h00C3);

        // Pop across FFFF -> 0000.
        run_op(3'd3, 2'd0, 16'hFFFF);
        @(negedge clk); ram[8'hFF] = 8'h11; ram[8'h00] = 8'h22;
        run_op(3'd1, 2'd1, 16'h0000);
        chk("R6 pop across wrap value", g_out, 16'h2211);
        chk("R6 pop wraps sp", sp, 16'h0001);

        // Exchange with S+1 wrapping.
        run_op(3'd3, 2'd0, 16'hFFFF);
        run_op(3'd2, 2'd0, 16'h7766);
        chk("R3 R6 exchange at FFFF value", g_out, 16'h2211);
        chk("R3 R6 exchange keeps sp", sp, 16'hFFFF);
        chk("R3 R6 H to 0000", {8'd0, ram[8'h00]}, 16'h0077);
        chk("R3 L to FFFF", {8'd0, ram[8'hFF]}, 16'h0066);

        // Reserved opcodes do nothing.
        for (int r = 6; r <= 7; r++) begin
            automatic int w0 = we_cnt;
            automatic int d0 = done_cnt;
            run_op(3'(r), 2'd0, 16'h1111);
            chk("R9 no done on reserved op", 16'(done_cnt - d0), 16'd0);
            chk("R9 no write on reserved op", 16'(we_cnt - w0), 16'd0);
            chk("R9 sp unchanged", sp, 16'hFFFF);
        end

        // Start held during a push is ignored; done is a single pulse.
        @(negedge clk);
        start = 1'b1; op_i = 3'd0; din_i = 16'h0F0E;
        @(negedge clk);
        op_i = 3'd3; din_i = 16'h0000;
        @(negedge clk);
        chk("R8 done after push with start held", {15'd0, done}, 16'd1);
        start = 1'b0;
        @(negedge clk);
        chk("R8 done falls after one cycle", {15'd0, done}, 16'd0);
        chk("R8 busy start ignored sp", sp, 16'hFFFD);
        @(negedge clk);
        chk("R7 no write when idle", {15'd0, mem_we}, 16'd0);
        chk("R1 low byte after held start", {8'd0, ram[8'hFD]}, 16'h000E);

        summary();
    end
endmodule